// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter of a microcoded stack processor and applies one PC operation on each microstep the sequencer issues. There are five operations: hold, step forward by one, load the ALU result, load the ALU result only if the low byte of operand register B is nonzero, and go to a fixed trap vector. Absolute jumps load a target the ALU passes through. Relative jumps load a PC plus sign-extended 8-bit offset that the ALU has already added. Conditional jumps hand their popped condition byte to the block as `cond_byte`.

Calls and trapping opcodes (divide, unimplemented, and so on) must put the current 16-bit PC on the return stack before the redirect. The block offers that return address as a valid/ready stream. The microstep that requests the push stalls until the return stack accepts the word: `ret_valid` follows `step & push_ret`, and `ret_addr` stays stable while `ret_ready` is low. The PC operation of that microstep is applied on the same edge as the accepting handshake, and never earlier. `step_done` tells the sequencer when it may advance. The stack-fault path reads the handler address from the device space through the ALU. Here it is just an ordinary load of the ALU result.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is loaded with parameter `RESET_PC` (asynchronous reset).
- R2: An applied microstep with `pc_op` = 1 (increment) makes `pc` equal to the old `pc` plus one, wrapping from 0xFFFF to 0x0000.
- R3: An applied microstep with `pc_op` = 2 (jump) loads `alu_result` into `pc`.
- R4: An applied microstep with `pc_op` = 3 (conditional jump) loads `alu_result` when `cond_byte` is nonzero. When `cond_byte` is zero it leaves `pc` unchanged.
- R5: An applied microstep with `pc_op` = 4 (trap) loads parameter `TRAP_VEC` into `pc`.
- R6: `pc_op` = 0 (hold) and the unused codes 5, 6 and 7 leave `pc` unchanged.
- R7: While `step` is low, `pc` is unchanged whatever `pc_op` and the data inputs carry.
- R8: `ret_valid` is high exactly when `step` and `push_ret` are both high, and `ret_addr` then carries the current `pc`, before the update.
- R9: While `ret_valid` is high and `ret_ready` is low, `step_done` is low, `pc` is held and `redirect` is low. The operation is applied at the edge where `ret_ready` is high.
- R10: `redirect` is high in an applied microstep that loads a new target (jump, taken conditional jump, trap). It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | A microstep is presented this cycle |
| pc_op | input | 3 | PC operation code (0 hold, 1 increment, 2 jump, 3 conditional jump, 4 trap) |
| push_ret | input | 1 | Microstep pushes the current PC to the return stack |
| alu_result | input | 16 | Registered ALU output used as jump target |
| cond_byte | input | 8 | Low byte of operand B, the branch condition |
| ret_ready | input | 1 | Return stack accepts the pushed address |
| pc | output | 16 | Current program counter |
| ret_valid | output | 1 | Return address push is offered |
| ret_addr | output | 16 | Return address being pushed |
| step_done | output | 1 | The microstep's PC operation is applied at the coming edge |
| redirect | output | 1 | The applied operation loads a non-sequential target |

## Verification
The bench builds the block with `RESET_PC` = 0xFFFE and `TRAP_VEC` = 0x0200. With the first value, two increments after reset reach the wrap from 0xFFFF to 0x0000 at once. The second value differs from every ALU target the bench uses, so a trap cannot be mistaken for a jump. A call is held off by the return stack for two cycles. This shows that the PC, `redirect` and the offered address all stay frozen until the handshake completes.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [2:0] {
    PCOP_HOLD    = 3'd0,
    PCOP_INCR    = 3'd1,
    PCOP_JUMP    = 3'd2,
    PCOP_JUMP_NZ = 3'd3,
    PCOP_TRAP    = 3'd4
  } pc_op_e;
endpackage

// File: rtl/pcb_cond.sv
// Branch condition: any set bit in the condition byte takes the branch.
module pcb_cond #(
  parameter int COND_W = 8
) (
  input  logic [COND_W-1:0] cond,
  output logic              nonzero
);
  assign nonzero = |cond;
endmodule

// File: rtl/pcb_next.sv
// Next-PC selection for one microstep.
module pcb_next #(
  parameter int          PC_W     = 16,
  parameter logic [PC_W-1:0] TRAP_VEC = '0
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] target,
  input  logic            cond_nz,
  output logic [PC_W-1:0] pc_nxt,
  output logic            jumps
);
  import pcb_pkg::*;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  always_comb begin
    pc_nxt = pc_cur;
    jumps  = 1'b0;
    case (op)
      PCOP_INCR:    pc_nxt = pc_cur + ONE;
      PCOP_JUMP:    begin pc_nxt = target;   jumps = 1'b1; end
      PCOP_JUMP_NZ: if (cond_nz) begin pc_nxt = target; jumps = 1'b1; end
      PCOP_TRAP:    begin pc_nxt = TRAP_VEC; jumps = 1'b1; end
      default:      pc_nxt = pc_cur;
    endcase
  end
endmodule

// File: rtl/pcb_reg.sv
// PC register with enable and asynchronous reset to the start address.
module pcb_reg #(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_PC;
    else if (en) q <= d;
  end

  assert_reset_pc_R1: assert property (@(posedge clk)
    !rst_n |=> (q == RESET_PC));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int                PC_W     = 16,
  parameter int                COND_W   = 8,
  parameter logic [PC_W-1:0]   RESET_PC = 16'h0100,
  parameter logic [PC_W-1:0]   TRAP_VEC = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        pc_op,
  input  logic              push_ret,
  input  logic [PC_W-1:0]   alu_result,
  input  logic [COND_W-1:0] cond_byte,
  input  logic              ret_ready,
  output logic [PC_W-1:0]   pc,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_addr,
  output logic              step_done,
  output logic              redirect
);
  import pcb_pkg::*;

  logic            cond_nz;
  logic [PC_W-1:0] pc_nxt;
  logic            jumps;

  pcb_cond #(.COND_W(COND_W)) u_cond (.cond(cond_byte), .nonzero(cond_nz));

  pcb_next #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_next (
    .pc_cur(pc), .op(pc_op), .target(alu_result), .cond_nz(cond_nz),
    .pc_nxt(pc_nxt), .jumps(jumps)
  );

  // A push must be accepted before the operation may take effect.
  assign ret_valid = step & push_ret;
  assign ret_addr  = pc;
  assign step_done = step & (~push_ret | ret_ready);
  assign redirect  = step_done & jumps;

  pcb_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_reg (
    .clk(clk), .rst_n(rst_n), .en(step_done), .d(pc_nxt), .q(pc)
  );

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && pc_op == PCOP_INCR) |=> (pc == $past(pc) + PC_W'(1)));
  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && pc_op == PCOP_JUMP) |=> (pc == $past(alu_result)));
  assert_cond_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && pc_op == PCOP_JUMP_NZ && cond_byte == '0) |=> $stable(pc));
  assert_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && pc_op == PCOP_TRAP) |=> (pc == TRAP_VEC));
  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> $stable(pc));
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |-> (!step_done && !redirect));
endmodule

// File: tb/sim_pc_branch_unit.sv
`timescale 1ns/1ps
module sim_pc_branch_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, push_ret = 0, ret_ready = 0;
  logic [2:0] pc_op = 0;
  logic [15:0] alu_result = 0;
  logic [7:0] cond_byte = 0;
  logic [15:0] pc, ret_addr;
  logic ret_valid, step_done, redirect;
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [15:0] RST = 16'hFFFE;
  localparam logic [15:0] TRP = 16'h0200;

  always #2.5 clk = ~clk;

  pc_branch_unit #(.RESET_PC(RST), .TRAP_VEC(TRP)) u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .pc_op(pc_op), .push_ret(push_ret),
    .alu_result(alu_result), .cond_byte(cond_byte), .ret_ready(ret_ready),
    .pc(pc), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .step_done(step_done), .redirect(redirect)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one microstep; check comb outputs before the edge, pc after it.
  task automatic apply(input string req, input logic s, input logic [2:0] op,
                       input logic [15:0] tgt, input logic [7:0] cb,
                       input logic push, input logic rdy,
                       input logic exp_redir, input logic [15:0] exp_pc);
    @(negedge clk);
    step = s; pc_op = op; alu_result = tgt; cond_byte = cb;
    push_ret = push; ret_ready = rdy;
    #1;
    check({req, " redirect"}, 16'(redirect), 16'(exp_redir));
    @(posedge clk); #1;
    check({req, " pc"}, pc, exp_pc);
  endtask

  task automatic t_reset;  // R1
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 check("R1 reset pc", pc, RST);
    check("R8 idle ret_valid", 16'(ret_valid), 16'd0);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_incr;  // R2 wrap
    apply("R2 incr", 1, 3'd1, 16'h5555, 8'h00, 0, 0, 0, 16'hFFFF);
    apply("R2 wrap", 1, 3'd1, 16'h5555, 8'h00, 0, 0, 0, 16'h0000);
  endtask

  task automatic t_jump;  // R3 R10
    apply("R3 jump", 1, 3'd2, 16'h1234, 8'h00, 0, 0, 1, 16'h1234);
  endtask

  task automatic t_cond;  // R4 R10
    apply("R4 not taken", 1, 3'd3, 16'h7777, 8'h00, 0, 0, 0, 16'h1234);
    apply("R4 taken msb", 1, 3'd3, 16'h2000, 8'h80, 0, 0, 1, 16'h2000);
    apply("R4 taken lsb", 1, 3'd3, 16'h2468, 8'h01, 0, 0, 1, 16'h2468);
  endtask

  task automatic t_trap;  // R5
    apply("R5 trap", 1, 3'd4, 16'h9999, 8'h00, 0, 0, 1, TRP);
  endtask

  task automatic t_hold;  // R6
    for (int c = 0; c < 8; c++)
      if (c == 0 || c > 4)
        apply("R6 hold/unused", 1, 3'(c), 16'hBEEF, 8'hFF, 0, 0, 0, TRP);
  endtask

  task automatic t_idle;  // R7
    apply("R7 no step jump", 0, 3'd2, 16'hBEEF, 8'hFF, 0, 1, 0, TRP);
    apply("R7 no step trap", 0, 3'd4, 16'hBEEF, 8'hFF, 1, 1, 0, TRP);
  endtask

  task automatic t_call;  // R8 R9
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      step = 1; pc_op = 3'd2; alu_result = 16'h3000; cond_byte = 0;
      push_ret = 1; ret_ready = 0;
      #1;
      check("R8 ret_valid", 16'(ret_valid), 16'd1);
      check("R8 ret_addr", ret_addr, TRP);
      check("R9 step_done low", 16'(step_done), 16'd0);
      check("R9 redirect low", 16'(redirect), 16'd0);
      @(posedge clk); #1;
      check("R9 pc held", pc, TRP);
    end
    @(negedge clk) ret_ready = 1;
    #1;
    check("R9 step_done", 16'(step_done), 16'd1);
    check("R10 call redirect", 16'(redirect), 16'd1);
    check("R8 ret_addr at accept", ret_addr, TRP);
    @(posedge clk); #1;
    check("R9 call target", pc, 16'h3000);
    @(negedge clk) begin step = 0; push_ret = 0; end
    #1 check("R8 ret_valid drops", 16'(ret_valid), 16'd0);
  endtask

  initial begin
    t_reset();
    t_incr();
    t_jump();
    t_cond();
    t_trap();
    t_hold();
    t_idle();
    t_call();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule